// File: doc/BRIEF.md
# Memory Controller Operating State Machine

This block is the top-level operating-state machine of a DDR protocol controller. Software issues mode requests through a small request port: configure, go, sleep and wakeup. The block moves the controller between memory initialisation, configuration, normal access and low power. No state is ever entered directly. Each move first passes through a request state that is visible in the status word. The request state completes only when the command path signals that it is ready.

The status word reports the present state and, while the controller is in or around low power, what caused the low-power entry. Low power can be requested by software. It can also be entered by the hardware on its own, when the hardware low-power enable is set and the DRAM has been idle for a programmable number of cycles. A hardware-entered low-power state also leaves on its own as soon as the DRAM stops being idle. A software-entered one waits for an explicit wakeup.

Top module: `opsm_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status reads 0x00: state init-memory (0) and trigger source 0.
- R2: A configure request (req_code 1) sampled in init-memory (0) or access (3) moves the state to config-request (2) on the next edge. The state then moves to config (1).
- R3: A go request (req_code 2) sampled in config (1) moves the state to access-request (4) on the next edge. The state then moves to access (3).
- R4: A sleep request (req_code 3) sampled in access moves the state to low-power-entry-request (6) with trigger source 2 (software). The state then moves to low-power (5), and the source is kept.
- R5: A wakeup request (req_code 4) sampled in low-power moves the state to low-power-exit-request (7). The state then moves to access, and the trigger source clears to 0.
- R6: Every request state (2, 4, 6, 7) lasts at least one cycle. It is left on the first later edge at which cmd_ready is sampled high, and it holds while cmd_ready is low.
- R7: An illegal request has no effect on status. Illegal means req_code 0, 5, 6 or 7, a code not legal in the current state, or any request made while in a request state.
- R8: With hw_lp_en high in access, once dram_idle has been sampled high on IDLE_CYCLES consecutive edges, the state moves to low-power-entry-request with trigger source 1 (hardware). If hw_lp_en is low, or idle breaks before that count, no entry occurs.
- R9: In access, a valid software request sampled in the same cycle as the hardware idle entry wins.
- R10: In low-power entered by hardware (source 1), dram_idle sampled low moves the state to low-power-exit-request. In low-power entered by software (source 2), dram_idle has no effect.
- R11: status[2:0] holds the state and status[6:4] holds the trigger source. The source is non-zero only in states 5, 6 and 7. Bits 3 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software mode request strobe |
| req_code | input | 3 | Request: 0 init, 1 configure, 2 go, 3 sleep, 4 wakeup |
| cmd_ready | input | 1 | Command path ready; completes a request state |
| dram_idle | input | 1 | DRAM idle indication from the command path |
| hw_lp_en | input | 1 | Allows hardware-triggered low-power entry |
| status | output | 8 | [2:0] state, [6:4] low-power trigger source |

## Verification
The checker watches several properties on every cycle. Config is only ever entered from config-request, access from access-request or low-power-exit-request, and low-power from low-power-entry-request. A request state never moves while ready is low, and the status reserved bits and source field stay well formed. Behaviours that depend on a sequence of stimulus can only be shown by the bench scenarios, compared against its reference model. These are the idle count reaching its threshold, software winning over a simultaneous hardware entry, illegal requests being dropped, and the different exit rules of the two low-power flavours.

// File: rtl/opsm_pkg.sv
package opsm_pkg;

  localparam int unsigned STATE_W  = 3;
  localparam int unsigned SRC_W    = 3;
  localparam int unsigned STATUS_W = 8;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LP_ENT  = 3'd6,
    ST_LP_EXIT = 3'd7
  } op_state_e;

  typedef enum logic [2:0] {
    RQ_INIT  = 3'd0,
    RQ_CFG   = 3'd1,
    RQ_GO    = 3'd2,
    RQ_SLEEP = 3'd3,
    RQ_WAKE  = 3'd4
  } op_req_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_HW   = 3'd1,
    SRC_SW   = 3'd2
  } lp_src_e;

  typedef struct packed {
    logic cfg;
    logic go;
    logic sleep;
    logic wake;
  } req_hit_t;

endpackage

// File: rtl/opsm_req_decode.sv
module opsm_req_decode
  import opsm_pkg::*;
(
  input  op_state_e        state,
  input  logic             req_valid,
  input  logic [2:0]       req_code,
  output req_hit_t         hit
);

  logic is_cfg, is_go, is_sleep, is_wake;

  always_comb begin
    is_cfg   = req_valid && (req_code == RQ_CFG);
    is_go    = req_valid && (req_code == RQ_GO);
    is_sleep = req_valid && (req_code == RQ_SLEEP);
    is_wake  = req_valid && (req_code == RQ_WAKE);
  end

  // Only requests legal in the present state get through.
  always_comb begin
    hit       = '0;
    hit.cfg   = is_cfg   && ((state == ST_INIT) || (state == ST_ACC));
    hit.go    = is_go    && (state == ST_CFG);
    hit.sleep = is_sleep && (state == ST_ACC);
    hit.wake  = is_wake  && (state == ST_LP);
  end

endmodule

// File: rtl/opsm_idle_qual.sv
module opsm_idle_qual #(
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic idle,
  output logic fire
);

  localparam int unsigned CNT_W = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);

  logic qualify;
  assign qualify = arm && idle;

  generate
    if (IDLE_CYCLES <= 1) begin : g_direct
      assign fire = qualify;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_d = cnt_q;
        if (!qualify) begin
          cnt_d = '0;
        end else if (cnt_q != CNT_LAST) begin
          cnt_d = cnt_q + 1'b1;
        end
        cnt_en = (cnt_d != cnt_q);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign fire = qualify && (cnt_q == CNT_LAST);
    end
  endgenerate

endmodule

// File: rtl/opsm_status_pack.sv
module opsm_status_pack
  import opsm_pkg::*;
(
  input  op_state_e             state,
  input  lp_src_e               src,
  output logic [STATUS_W-1:0]   status
);

  always_comb begin
    status      = '0;
    status[2:0] = state;
    status[6:4] = src;
  end

endmodule

// File: rtl/opsm_ctrl.sv
module opsm_ctrl
  import opsm_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic       cmd_ready,
  input  logic       dram_idle,
  input  logic       hw_lp_en,
  output logic [7:0] status
);

  op_state_e state_q, state_d;
  lp_src_e   src_q, src_d;
  logic      upd_en;
  req_hit_t  hit;
  logic      hw_fire;
  logic      hw_arm;

  opsm_req_decode u_dec (
    .state     (state_q),
    .req_valid (req_valid),
    .req_code  (req_code),
    .hit       (hit)
  );

  assign hw_arm = (state_q == ST_ACC) && hw_lp_en;

  opsm_idle_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (hw_arm),
    .idle  (dram_idle),
    .fire  (hw_fire)
  );

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    unique case (state_q)
      ST_INIT: begin
        if (hit.cfg) state_d = ST_CFG_REQ;
      end
      ST_CFG: begin
        if (hit.go) state_d = ST_ACC_REQ;
      end
      ST_CFG_REQ: begin
        if (cmd_ready) state_d = ST_CFG;
      end
      ST_ACC: begin
        if (hit.cfg) begin
          state_d = ST_CFG_REQ;
        end else if (hit.sleep) begin
          state_d = ST_LP_ENT;
          src_d   = SRC_SW;
        end else if (hw_fire) begin
          state_d = ST_LP_ENT;
          src_d   = SRC_HW;
        end
      end
      ST_ACC_REQ: begin
        if (cmd_ready) state_d = ST_ACC;
      end
      ST_LP: begin
        if (hit.wake || ((src_q == SRC_HW) && !dram_idle)) state_d = ST_LP_EXIT;
      end
      ST_LP_ENT: begin
        if (cmd_ready) state_d = ST_LP;
      end
      ST_LP_EXIT: begin
        if (cmd_ready) begin
          state_d = ST_ACC;
          src_d   = SRC_NONE;
        end
      end
      default: begin
        state_d = ST_INIT;
        src_d   = SRC_NONE;
      end
    endcase
    upd_en = (state_d != state_q) || (src_d != src_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      src_q   <= SRC_NONE;
    end else if (upd_en) begin
      state_q <= state_d;
      src_q   <= src_d;
    end
  end

  opsm_status_pack u_stat (
    .state  (state_q),
    .src    (src_q),
    .status (status)
  );

endmodule

// File: rtl/opsm_ctrl_chk.sv
module opsm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic [7:0] status
);

  logic [2:0] st;
  logic [2:0] src;
  assign st  = status[2:0];
  assign src = status[6:4];

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] == 1'b0) && (status[7] == 1'b0));

  // R11
  src_only_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st < 3'd5) |-> (src == 3'd0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 3'd2 || st == 3'd4 || st == 3'd6 || st == 3'd7) && !cmd_ready) |=> $stable(st));

  // R2
  cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd1) |=> ((st != 3'd1) || ($past(st) == 3'd2)));

  // R3
  acc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd3) |=> ((st != 3'd3) || ($past(st) == 3'd4) || ($past(st) == 3'd7)));

  // R4
  lp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd5) |=> ((st != 3'd5) || ($past(st) == 3'd6)));

  // R4
  src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |=> ((st != 3'd5) || $stable(src)));

endmodule

bind opsm_ctrl opsm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .status    (status)
);

// File: tb/opsm_ctrl_test.sv
module opsm_ctrl_test;

  localparam int PERIOD = 10;
  localparam int IDLE   = 4;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_code;
  logic       cmd_ready;
  logic       dram_idle;
  logic       hw_lp_en;
  logic [7:0] status;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_req = "R1";

  // reference model state
  int m_st = 0;
  int m_src = 0;
  int m_cnt = 0;

  opsm_ctrl #(.IDLE_CYCLES(IDLE)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_code  (req_code),
    .cmd_ready (cmd_ready),
    .dram_idle (dram_idle),
    .hw_lp_en  (hw_lp_en),
    .status    (status)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_cnt = 0;
    end else begin
      bit v_ok, armed, trig;
      int ns, nsrc;
      v_ok  = req_valid;
      armed = (m_st == 3) && hw_lp_en && dram_idle;
      trig  = armed && (m_cnt >= IDLE - 1);
      ns = m_st; nsrc = m_src;
      if (m_st == 0 && v_ok && req_code == 1) ns = 2;
      else if (m_st == 1 && v_ok && req_code == 2) ns = 4;
      else if ((m_st == 2) && cmd_ready) ns = 1;
      else if ((m_st == 4) && cmd_ready) ns = 3;
      else if ((m_st == 6) && cmd_ready) ns = 5;
      else if ((m_st == 7) && cmd_ready) begin ns = 3; nsrc = 0; end
      else if (m_st == 3) begin
        if (v_ok && req_code == 1) ns = 2;
        else if (v_ok && req_code == 3) begin ns = 6; nsrc = 2; end
        else if (trig) begin ns = 6; nsrc = 1; end
      end else if (m_st == 5) begin
        if ((v_ok && req_code == 4) || (m_src == 1 && !dram_idle)) ns = 7;
      end
      m_cnt = armed ? ((m_cnt < IDLE - 1) ? m_cnt + 1 : m_cnt) : 0;
      m_st = ns; m_src = nsrc;
    end
  end

  task automatic check_now();
    logic [7:0] exp;
    exp = {1'b0, 3'(m_src), 1'b0, 3'(m_st)};
    vectors++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h at %0t", cur_req, status, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) check_now();

  task automatic drive(input bit v, input int code, input bit rdy, input bit idle,
                       input bit en, input int n);
    @(negedge clk); #1;
    req_valid = v; req_code = 3'(code); cmd_ready = rdy; dram_idle = idle; hw_lp_en = en;
    repeat (n) @(posedge clk);
  endtask

  task automatic quiet(input bit idle, input bit en, input int n);
    drive(0, 0, 1, idle, en, n);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_code = 0; cmd_ready = 1; dram_idle = 0; hw_lp_en = 0;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R7: illegal codes and illegal states from init-memory
    cur_req = "R7";
    drive(1, 2, 1, 0, 0, 1);
    drive(1, 0, 1, 0, 0, 1);
    drive(1, 5, 1, 0, 0, 1);
    drive(1, 3, 1, 0, 0, 1);
    drive(1, 4, 1, 0, 0, 1);
    quiet(0, 0, 1);

    // R2 configure from init with ready low: R6 holding
    cur_req = "R2";
    drive(1, 1, 0, 0, 0, 1);
    cur_req = "R6";
    drive(1, 3, 0, 0, 0, 3);
    drive(0, 0, 1, 0, 0, 2);

    // R3 go to access
    cur_req = "R3";
    drive(1, 2, 1, 0, 0, 1);
    quiet(0, 0, 2);

    // R4 software sleep, R10 idle ignored in software low power
    cur_req = "R4";
    drive(1, 3, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 2);
    quiet(0, 0, 2);
    cur_req = "R10";
    quiet(1, 1, 3);
    quiet(0, 1, 3);
    cur_req = "R7";
    drive(1, 1, 1, 0, 0, 2);

    // R5 wakeup
    cur_req = "R5";
    drive(1, 4, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 2);
    quiet(0, 0, 2);

    // R8 disabled, broken idle, then full count
    cur_req = "R8";
    quiet(1, 0, 8);
    quiet(1, 1, IDLE - 1);
    quiet(0, 1, 1);
    quiet(1, 1, IDLE + 2);
    cur_req = "R11";
    quiet(1, 1, 2);
    cur_req = "R10";
    quiet(0, 1, 4);

    // R9 software sleep collides with hardware entry
    cur_req = "R9";
    quiet(1, 1, IDLE - 1);
    drive(1, 3, 1, 1, 1, 1);
    quiet(0, 1, 3);
    cur_req = "R5";
    drive(1, 4, 1, 0, 1, 1);
    quiet(0, 0, 2);

    // R2 configure from access, then back
    cur_req = "R2";
    drive(1, 1, 1, 0, 0, 1);
    quiet(0, 0, 2);
    cur_req = "R3";
    drive(1, 2, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 2);
    quiet(0, 0, 2);

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule